// File: doc/BRIEF.md
# Single-Error-Correcting (6,3) Block Coder

This block protects three-bit data values with a systematic (6,3) linear block code. The encoder side takes a three-bit message and returns a six-bit codeword. The codeword is the message unchanged, followed by three parity bits. Each parity bit is the modulo-2 sum of a fixed pair of message bits.

The decoder side takes a six-bit received word and forms a three-bit syndrome from it. It compares the syndrome with the column pattern that each code position contributes. When one position matches, the decoder inverts that bit. It then returns the repaired word, the recovered message and three status flags. One syndrome value matches no position. That value is reported as uncorrectable, and the received word is passed through untouched.

Each side has its own valid strobe and registers its result one clock after the strobe.

Top module: `lbc_corrector`

## Requirements
- R1: Bit 5 of the codeword is the most significant. Bits [5:3] of `encCodeOut` equal message bits d1 d2 d3, where d1 is `encMsgIn[2]`. Bits [2:0] are c4 = d1^d3, c5 = d2^d3 and c6 = d1^d2, in that order.
- R2: `encValidOut` is high in exactly the cycle after a cycle with `encValidIn` high. `encCodeOut` is registered in that same edge.
- R3: The received bits are numbered r1..r6 from `decWordIn[5]` down to `decWordIn[0]`. The syndrome is s1 = r1^r3^r4, s2 = r2^r3^r5 and s3 = r1^r2^r6. When the syndrome is 000, the word is output unchanged and all three flags are low.
- R4: A syndrome 101, 011, 110, 100, 010 or 001 (s1 s2 s3) selects r1, r2, r3, r4, r5 or r6 respectively. That bit is inverted, and `errDetected` and `errCorrected` are set. For example, 110010 is corrected to 110110.
- R5: A syndrome of 111 sets `errDetected` and `errUncorrectable`, clears `errCorrected`, and outputs the received word unchanged.
- R6: `decMsgOut` equals bits [5:3] of `decWordOut`.
- R7: `decValidOut` is high in exactly the cycle after a cycle with `decValidIn` high. The data and flags are registered in that same edge.
- R8: Synchronous active-high `rst` clears both valid outputs, all flags and all data outputs.
- R9: `errCorrected` and `errUncorrectable` are never high together. Either of them implies `errDetected`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| encValidIn | input | 1 | Message strobe |
| encMsgIn | input | 3 | Message, d1 in bit 2 |
| encValidOut | output | 1 | Codeword valid |
| encCodeOut | output | 6 | Codeword, d1 in bit 5 |
| decValidIn | input | 1 | Received-word strobe |
| decWordIn | input | 6 | Received word, r1 in bit 5 |
| decValidOut | output | 1 | Decoder result valid |
| decWordOut | output | 6 | Corrected word |
| decMsgOut | output | 3 | Recovered message |
| errDetected | output | 1 | Syndrome was nonzero |
| errCorrected | output | 1 | One bit was inverted |
| errUncorrectable | output | 1 | Syndrome matched no position |

## Verification
The properties assume that every valid output follows a strobe from the previous cycle. On that basis they compare outputs with the inputs sampled one cycle earlier. The properties hold for any strobe pattern, including back-to-back strobes and both sides active in the same cycle.

The stimulus raises each strobe for a single cycle and samples the results half a clock later. It covers all 8 messages and all 64 received words, so every syndrome value is exercised, including the unmatched one.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  localparam int MSG_W  = 3;
  localparam int CODE_W = 6;
  localparam int CHK_W  = CODE_W - MSG_W;

  // Parity rows, index 0 belongs to d1; bit CHK_W-1 feeds c4 / s1.
  localparam logic [CHK_W-1:0] PAR_ROW [MSG_W] = '{3'b101, 3'b011, 3'b110};

  typedef struct packed {
    logic encLoad;
    logic decLoad;
  } strobe_t;

  // XOR of the parity rows selected by the message bits (msb = d1).
  function automatic logic [CHK_W-1:0] checkOf(input logic [MSG_W-1:0] msg);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < MSG_W; i++) begin
      if (msg[MSG_W-1-i]) acc = acc ^ PAR_ROW[i];
    end
    return acc;
  endfunction
endpackage

// File: rtl/lbc_ctrl.sv
module lbc_ctrl
  import lbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    encValidIn,
  input  logic    decValidIn,
  output strobe_t strobes,
  output logic    encValidOut,
  output logic    decValidOut
);
  always_comb begin
    strobes.encLoad = encValidIn;
    strobes.decLoad = decValidIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      encValidOut <= 1'b0;
      decValidOut <= 1'b0;
    end else begin
      encValidOut <= encValidIn;
      decValidOut <= decValidIn;
    end
  end
endmodule

// File: rtl/lbc_datapath.sv
module lbc_datapath
  import lbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [MSG_W-1:0]  encMsgIn,
  input  logic [CODE_W-1:0] decWordIn,
  output logic [CODE_W-1:0] encCodeOut,
  output logic [CODE_W-1:0] decWordOut,
  output logic [MSG_W-1:0]  decMsgOut,
  output logic              errDetected,
  output logic              errCorrected,
  output logic              errUncorrectable
);
  logic [CODE_W-1:0] encNext;
  logic [CHK_W-1:0]  syndrome;
  logic [CODE_W-1:0] flipVec;
  logic [CODE_W-1:0] fixedWord;
  logic              anyMatch;
  logic              synNonZero;

  assign encNext  = {encMsgIn, checkOf(encMsgIn)};
  assign syndrome = checkOf(decWordIn[CODE_W-1 -: MSG_W]) ^ decWordIn[CHK_W-1:0];

  // One comparator per code position against its parity-check column.
  for (genvar p = 0; p < CODE_W; p++) begin : g_locate
    if (p < MSG_W) begin : g_msgPos
      assign flipVec[CODE_W-1-p] = (syndrome == PAR_ROW[p]);
    end else begin : g_chkPos
      localparam logic [CHK_W-1:0] UNIT = CHK_W'(1) << (CODE_W-1-p);
      assign flipVec[CODE_W-1-p] = (syndrome == UNIT);
    end
  end

  assign anyMatch   = |flipVec;
  assign synNonZero = |syndrome;
  assign fixedWord  = decWordIn ^ flipVec;

  always_ff @(posedge clk) begin
    if (rst) begin
      encCodeOut       <= '0;
      decWordOut       <= '0;
      decMsgOut        <= '0;
      errDetected      <= 1'b0;
      errCorrected     <= 1'b0;
      errUncorrectable <= 1'b0;
    end else begin
      if (strobes.encLoad) encCodeOut <= encNext;
      if (strobes.decLoad) begin
        decWordOut       <= fixedWord;
        decMsgOut        <= fixedWord[CODE_W-1 -: MSG_W];
        errDetected      <= synNonZero;
        errCorrected     <= anyMatch;
        errUncorrectable <= synNonZero && !anyMatch;
      end
    end
  end
endmodule

// File: rtl/lbc_corrector.sv
module lbc_corrector
  import lbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              encValidIn,
  input  logic [MSG_W-1:0]  encMsgIn,
  output logic              encValidOut,
  output logic [CODE_W-1:0] encCodeOut,
  input  logic              decValidIn,
  input  logic [CODE_W-1:0] decWordIn,
  output logic              decValidOut,
  output logic [CODE_W-1:0] decWordOut,
  output logic [MSG_W-1:0]  decMsgOut,
  output logic              errDetected,
  output logic              errCorrected,
  output logic              errUncorrectable
);
  strobe_t strobes;

  lbc_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .encValidIn(encValidIn), .decValidIn(decValidIn),
    .strobes(strobes),
    .encValidOut(encValidOut), .decValidOut(decValidOut)
  );

  lbc_datapath u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .encMsgIn(encMsgIn), .decWordIn(decWordIn),
    .encCodeOut(encCodeOut), .decWordOut(decWordOut), .decMsgOut(decMsgOut),
    .errDetected(errDetected), .errCorrected(errCorrected),
    .errUncorrectable(errUncorrectable)
  );
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker
  import lbc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              encValidIn,
  input logic [MSG_W-1:0]  encMsgIn,
  input logic              encValidOut,
  input logic [CODE_W-1:0] encCodeOut,
  input logic              decValidIn,
  input logic [CODE_W-1:0] decWordIn,
  input logic              decValidOut,
  input logic [CODE_W-1:0] decWordOut,
  input logic [MSG_W-1:0]  decMsgOut,
  input logic              errDetected,
  input logic              errCorrected,
  input logic              errUncorrectable
);
  AST_ENC_SYSTEMATIC: assert property (@(posedge clk) disable iff (rst)
    encValidIn |=> encCodeOut[CODE_W-1 -: MSG_W] == $past(encMsgIn)); // R1
  AST_ENC_VALID: assert property (@(posedge clk) disable iff (rst)
    encValidIn |=> encValidOut); // R2
  AST_DEC_VALID: assert property (@(posedge clk) disable iff (rst)
    decValidIn |=> decValidOut); // R7
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
    (decValidOut && !errCorrected) |-> decWordOut == $past(decWordIn)); // R3
  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (rst)
    (decValidOut && errCorrected) |-> $countones(decWordOut ^ $past(decWordIn)) == 1); // R4
  AST_MSG_FIELD: assert property (@(posedge clk) disable iff (rst)
    decValidOut |-> decMsgOut == decWordOut[CODE_W-1 -: MSG_W]); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(errCorrected && errUncorrectable)); // R9
  AST_FLAG_DETECT: assert property (@(posedge clk) disable iff (rst)
    (errCorrected || errUncorrectable) |-> errDetected); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !encValidOut && !decValidOut && !errDetected && !errCorrected && !errUncorrectable); // R8
endmodule

bind lbc_corrector lbc_checker u_chk (.*);

// File: tb/lbc_corrector_bench.sv
module lbc_corrector_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       encValidIn;
  logic [2:0] encMsgIn;
  logic       encValidOut;
  logic [5:0] encCodeOut;
  logic       decValidIn;
  logic [5:0] decWordIn;
  logic       decValidOut;
  logic [5:0] decWordOut;
  logic [2:0] decMsgOut;
  logic       errDetected, errCorrected, errUncorrectable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lbc_corrector u_lbc_corrector (
    .clk(clk), .rst(rst),
    .encValidIn(encValidIn), .encMsgIn(encMsgIn),
    .encValidOut(encValidOut), .encCodeOut(encCodeOut),
    .decValidIn(decValidIn), .decWordIn(decWordIn),
    .decValidOut(decValidOut), .decWordOut(decWordOut), .decMsgOut(decMsgOut),
    .errDetected(errDetected), .errCorrected(errCorrected),
    .errUncorrectable(errUncorrectable)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expEncode(input logic [2:0] m);
    logic d1, d2, d3;
    {d1, d2, d3} = m;
    return {d1, d2, d3, d1 ^ d3, d2 ^ d3, d1 ^ d2};
  endfunction

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; encValidIn = 0; encMsgIn = '0; decValidIn = 0; decWordIn = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 valids", {6'b0, encValidOut, decValidOut}, 8'b0);
    check("R8 flags", {5'b0, errDetected, errCorrected, errUncorrectable}, 8'b0);
    check("R8 data", {2'b0, decWordOut}, 8'b0);
    rst = 1'b0;

    // R1, R2: every message
    for (int m = 0; m < 8; m++) begin
      encMsgIn = 3'(m); encValidIn = 1'b1;
      @(negedge clk);
      encValidIn = 1'b0;
      check("R2 encValidOut", {7'b0, encValidOut}, 8'd1);
      check("R1 codeword", {2'b0, encCodeOut}, {2'b0, expEncode(3'(m))});
      @(negedge clk);
      check("R2 valid drops", {7'b0, encValidOut}, 8'd0);
      check("R2 code holds", {2'b0, encCodeOut}, {2'b0, expEncode(3'(m))});
    end
    check("R1 011", {2'b0, expEncode(3'b011)}, 8'b00011101);

    // R3..R7, R9: every received word
    for (int w = 0; w < 64; w++) begin
      logic [5:0] r, expWord;
      logic [2:0] s;
      logic eDet, eCor, eUnc;
      r = 6'(w);
      s = {r[5] ^ r[3] ^ r[2], r[4] ^ r[3] ^ r[1], r[5] ^ r[4] ^ r[0]};
      expWord = r; eCor = 1'b1; eUnc = 1'b0;
      case (s)
        3'b101: expWord[5] = ~r[5];
        3'b011: expWord[4] = ~r[4];
        3'b110: expWord[3] = ~r[3];
        3'b100: expWord[2] = ~r[2];
        3'b010: expWord[1] = ~r[1];
        3'b001: expWord[0] = ~r[0];
        3'b111: begin eCor = 1'b0; eUnc = 1'b1; end
        default: eCor = 1'b0;
      endcase
      eDet = (s != 3'b000);
      decWordIn = r; decValidIn = 1'b1;
      @(negedge clk);
      decValidIn = 1'b0;
      check("R7 decValidOut", {7'b0, decValidOut}, 8'd1);
      if (s == 3'b000) check("R3 clean word", {2'b0, decWordOut}, {2'b0, r});
      else if (s == 3'b111) check("R5 passthrough", {2'b0, decWordOut}, {2'b0, r});
      else check("R4 corrected", {2'b0, decWordOut}, {2'b0, expWord});
      check("R6 message", {5'b0, decMsgOut}, {5'b0, expWord[5:3]});
      check("R4 R5 R9 flags", {5'b0, errDetected, errCorrected, errUncorrectable},
            {5'b0, eDet, eCor, eUnc});
      @(negedge clk);
      check("R7 valid drops", {7'b0, decValidOut}, 8'd0);
    end

    // R4 worked case
    decWordIn = 6'b110010; decValidIn = 1'b1;
    @(negedge clk);
    decValidIn = 1'b0;
    check("R4 110010", {2'b0, decWordOut}, 8'b00110110);

    // R8: reset after activity
    rst = 1'b1;
    @(negedge clk);
    check("R8 reclear", {5'b0, encValidOut, decValidOut, errDetected}, 8'b0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule